// File: doc/BRIEF.md
# Clock-Stop and Peripheral-Reset Control Bank

This block is a small register bank for a chip's system-control area. It keeps one stop bit for each of 64 peripheral clocks and one hold-in-reset bit for each of 64 peripherals. It turns these bits into per-peripheral clock-enable, reset and "clock running" outputs. Each group of 64 bits is stored as two 32-bit words.

Software never writes a word directly. Each word has two addresses. A write to the lower address sets the bits that are 1 in the data. A write to the address 4 above it clears the bits that are 1 in the data. Bits written as 0 keep their value in both cases, so separate drivers can change their own bits without a read-modify-write.

One clock index has reversed polarity. For that index, a stored 1 enables the clock and a 0 stops it. The bank also reports a peripheral's clock as not running while that peripheral is held in reset, whatever its stop bit holds.

Top module: `periph_gate_bank`

## Requirements
- R1: Reset words are at offset 0x040 (indices 0..31) and 0x050 (indices 32..63). Clock-stop words are at 0x080 (indices 0..31) and 0x090 (indices 32..63). Index i lives in word i/32, at bit i%32.
- R2: A write to a word's base offset ORs the write data into the word. The change is visible on the outputs after the write's clock edge, and bits written as 0 do not change.
- R3: A write to base+4 clears each bit of the word that is 1 in the write data. Bits written as 0 do not change.
- R4: For every clock index except 14, `clk_en[i]` is the inverse of its stored stop bit (1 = stopped).
- R5: Clock index 14 is reversed: `clk_en[14]` equals its stored bit (1 = enabled).
- R6: `periph_rst[i]` equals the stored reset bit i (1 = held in reset).
- R7: `clk_run[i]` is 1 only when `clk_en[i]` is 1 and `periph_rst[i]` is 0.
- R8: After `rst_n` low at a clock edge, all reset bits are 1 and all stop bits are 1 except index 14, which is 0. So every `clk_en` is 0.
- R9: A read of either the base or the base+4 address of a word returns the word's current value on `rd_data`, with `rd_valid` high, in the cycle after the request edge.
- R10: Writes to any other offset, including unaligned ones, change nothing. Reads of such offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Request strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | WORD_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | WORD_W | Read data |
| clk_en | output | NUM_IDX | Per-peripheral clock enable |
| periph_rst | output | NUM_IDX | Per-peripheral reset, active high |
| clk_run | output | NUM_IDX | Clock enabled and peripheral out of reset |

## Verification
The bench builds the bank with its default parameters: 64 indices in two 32-bit words per group, a 12-bit offset, and the reversed index at 14. This places the reversed bit in the lower clock word. It also gives index 33 a home in the upper word, at bit 1. Random set, clear and read traffic mixes the eight defined offsets with arbitrary offsets. This reaches both words of both groups, the gaps between them and unaligned offsets. Directed steps pin down the bit-14 polarity, reset masking of `clk_run`, and the upper-word mapping.

// File: rtl/pgb_pkg.sv
// Package: shared constants and helpers for the clock-stop/reset bank.
// Assumes word width divides the index count evenly.
package pgb_pkg;

    // Group selector: which bank a word belongs to
    typedef enum logic {
        GRP_RST = 1'b0,
        GRP_CLK = 1'b1
    } grp_t;

    // Power-on value of one word: all ones, except the reversed bit in clock words
    function automatic logic [31:0] word_reset_val(input grp_t grp, input int word, input int inv_idx);
        logic [31:0] v;
        v = '1;
        if (grp == GRP_CLK && (inv_idx / 32) == word)
            v[inv_idx % 32] = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/pgb_addr_decode.sv
// Module: address decoder. For each word it flags a set-port hit or a
// clear-port hit and raises `hit` for any defined offset.
// Assumes the words of a group are WORD_STRIDE apart and the clear port sits at base+CLR_OFS.
module pgb_addr_decode #(
    parameter int ADDR_W      = 12,
    parameter int NUM_WORDS   = 2,
    parameter int RST_BASE    = 'h040,
    parameter int CLK_BASE    = 'h080,
    parameter int WORD_STRIDE = 'h10,
    parameter int CLR_OFS     = 'h4,
    localparam int NSEL       = 2 * NUM_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [NSEL-1:0]   sel_set,
    output logic [NSEL-1:0]   sel_clr,
    output logic              hit
);

    // Compare the offset against every word's set and clear address
    always_comb begin
        sel_set = '0;
        sel_clr = '0;
        for (int g = 0; g < 2; g++) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                int base;
                base = ((g == 0) ? RST_BASE : CLK_BASE) + w * WORD_STRIDE;
                if (addr == ADDR_W'(base))           sel_set[g*NUM_WORDS+w] = 1'b1;
                if (addr == ADDR_W'(base + CLR_OFS)) sel_clr[g*NUM_WORDS+w] = 1'b1;
            end
        end
        hit = |{sel_set, sel_clr};
    end

    AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_set, sel_clr})); // R1

endmodule

// File: rtl/pgb_sc_word.sv
// Module: one set/clear register word. A set strobe ORs data in and a clear
// strobe removes the data's 1-bits. Assumes at most one strobe per cycle.
module pgb_sc_word #(
    parameter int          WIDTH     = 32,
    parameter logic [31:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] data,
    output logic [WIDTH-1:0] q
);

    // Hold the word; apply set or clear strobes
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= RESET_VAL[WIDTH-1:0];
        else if (set_en) q <= q | data;
        else if (clr_en) q <= q & ~data;
    end

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((q & $past(data)) == $past(data))); // R2
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((q & $past(data)) == '0)); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en || clr_en) |=> $stable(q)); // R10

endmodule

// File: rtl/pgb_status.sv
// Module: turns stored stop and reset bits into enable and running flags.
// Assumes exactly one index (INV_IDX) uses reversed stop-bit polarity.
module pgb_status #(
    parameter int NUM_IDX = 64,
    parameter int INV_IDX = 14
) (
    input  logic [NUM_IDX-1:0] stop_bits,
    input  logic [NUM_IDX-1:0] rst_bits,
    output logic [NUM_IDX-1:0] clk_en,
    output logic [NUM_IDX-1:0] clk_run
);

    for (genvar i = 0; i < NUM_IDX; i++) begin : g_bit
        if (i == INV_IDX) begin : g_inv
            // Reversed bit: stored 1 enables the clock
            assign clk_en[i] = stop_bits[i];
        end else begin : g_norm
            // Normal bit: stored 1 stops the clock
            assign clk_en[i] = ~stop_bits[i];
        end
        // A peripheral held in reset never reports a running clock
        assign clk_run[i] = clk_en[i] & ~rst_bits[i];
    end

endmodule

// File: rtl/periph_gate_bank.sv
// Module: top of the clock-stop/reset control bank. Decodes one bus access
// per cycle, updates the set/clear words and returns registered read data.
// Assumes a single-cycle request strobe and that bus_addr is a byte offset.
module periph_gate_bank #(
    parameter int ADDR_W      = 12,
    parameter int WORD_W      = 32,
    parameter int NUM_IDX     = 64,
    parameter int INV_IDX     = 14,
    parameter int RST_BASE    = 'h040,
    parameter int CLK_BASE    = 'h080,
    parameter int WORD_STRIDE = 'h10,
    parameter int CLR_OFS     = 'h4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic               rd_valid,
    output logic [WORD_W-1:0]  rd_data,
    output logic [NUM_IDX-1:0] clk_en,
    output logic [NUM_IDX-1:0] periph_rst,
    output logic [NUM_IDX-1:0] clk_run
);
    import pgb_pkg::*;

    localparam int NUM_WORDS = NUM_IDX / WORD_W;
    localparam int NSEL      = 2 * NUM_WORDS;

    logic [NSEL-1:0]   sel_set, sel_clr;
    logic              hit;
    logic [WORD_W-1:0] words [NSEL];
    logic [NUM_IDX-1:0] rst_bits, stop_bits;
    logic [WORD_W-1:0] rd_next;

    pgb_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .RST_BASE(RST_BASE),
        .CLK_BASE(CLK_BASE), .WORD_STRIDE(WORD_STRIDE), .CLR_OFS(CLR_OFS)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr),
        .sel_set(sel_set), .sel_clr(sel_clr), .hit(hit)
    );

    // One word per group per 32 indices; word k = group*NUM_WORDS + w
    for (genvar k = 0; k < NSEL; k++) begin : g_word
        localparam grp_t GRP = (k < NUM_WORDS) ? GRP_RST : GRP_CLK;
        localparam int   W   = k % NUM_WORDS;
        pgb_sc_word #(
            .WIDTH(WORD_W), .RESET_VAL(word_reset_val(GRP, W, INV_IDX))
        ) u_word (
            .clk(clk), .rst_n(rst_n),
            .set_en(bus_valid && bus_write && sel_set[k]),
            .clr_en(bus_valid && bus_write && sel_clr[k]),
            .data(bus_wdata), .q(words[k])
        );
        if (k < NUM_WORDS) begin : g_rst
            assign rst_bits[W*WORD_W +: WORD_W] = words[k];
        end else begin : g_clk
            assign stop_bits[W*WORD_W +: WORD_W] = words[k];
        end
    end

    pgb_status #(.NUM_IDX(NUM_IDX), .INV_IDX(INV_IDX)) u_stat (
        .stop_bits(stop_bits), .rst_bits(rst_bits),
        .clk_en(clk_en), .clk_run(clk_run)
    );

    assign periph_rst = rst_bits;

    // Select the addressed word for a read; undefined offsets give zero
    always_comb begin
        rd_next = '0;
        for (int k = 0; k < NSEL; k++)
            if (sel_set[k] || sel_clr[k]) rd_next = words[k];
    end

    // Register read response one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= bus_valid && !bus_write;
            if (bus_valid && !bus_write) rd_data <= hit ? rd_next : '0;
        end
    end

    AST_RST_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (periph_rst == '1 && clk_en == '0)); // R8
    AST_RUN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_rst & clk_run) == '0); // R7
    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> rd_valid); // R9

endmodule

// File: tb/periph_gate_bank_test.sv
module periph_gate_bank_test;
    localparam int AW = 12;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic rd_valid;
    logic [31:0] rd_data;
    logic [63:0] clk_en, periph_rst, clk_run;

    int total = 0, bad = 0;
    bit done = 0;
    logic [63:0] m_rst, m_stop;   // bench model of stored bits

    periph_gate_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .clk_en(clk_en), .periph_rst(periph_rst), .clk_run(clk_run)
    );

    always #4 clk = ~clk; // 125 MHz

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // R1 map: returns word slot (0,1 reset; 2,3 stop) or -1; is_clr for base+4
    function automatic int decode(input logic [AW-1:0] a, output bit is_clr);
        int bases[4] = '{'h040, 'h050, 'h080, 'h090};
        is_clr = 0;
        for (int k = 0; k < 4; k++) begin
            if (a == AW'(bases[k])) return k;
            if (a == AW'(bases[k] + 4)) begin is_clr = 1; return k; end
        end
        return -1;
    endfunction

    function automatic logic [31:0] model_word(input int k);
        case (k)
            0: return m_rst[31:0];
            1: return m_rst[63:32];
            2: return m_stop[31:0];
            default: return m_stop[63:32];
        endcase
    endfunction

    function automatic logic [63:0] exp_en();
        logic [63:0] e = ~m_stop;
        e[14] = m_stop[14];   // R5 reversed index
        return e;
    endfunction

    task automatic check_outputs(input string why);
        check({"R6 periph_rst ", why}, periph_rst, m_rst);
        check({"R4/R5 clk_en ", why}, clk_en, exp_en());
        check({"R7 clk_run ", why}, clk_run, exp_en() & ~m_rst);
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
        bit c; int k; logic [31:0] v;
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
        k = decode(a, c);
        if (k >= 0) begin
            v = model_word(k);
            v = c ? (v & ~d) : (v | d);   // R2 set / R3 clear
            case (k)
                0: m_rst[31:0] = v;
                1: m_rst[63:32] = v;
                2: m_stop[31:0] = v;
                default: m_stop[63:32] = v;
            endcase
        end
    endtask

    task automatic bus_rd(input logic [AW-1:0] a);
        bit c; int k; logic [31:0] e;
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        @(negedge clk);
        bus_valid = 0;
        k = decode(a, c);
        e = (k >= 0) ? model_word(k) : 32'h0;
        check("R9 rd_valid", {63'b0, rd_valid}, 64'd1);
        if (k >= 0) check("R9 rd_data", {32'b0, rd_data}, {32'b0, e});
        else        check("R10 rd_data undefined", {32'b0, rd_data}, 64'd0);
    endtask

    initial begin
        int seed;
        logic [AW-1:0] defs[8] = '{12'h040, 12'h044, 12'h050, 12'h054, 12'h080, 12'h084, 12'h090, 12'h094};
        seed = $urandom(32'h5EED_0017);
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_rst = '1; m_stop = '1; m_stop[14] = 1'b0;
        @(negedge clk);
        // R8 reset defaults
        check("R8 periph_rst default", periph_rst, '1);
        check("R8 clk_en default", clk_en, '0);
        bus_rd(12'h080);
        check("R8 stop word0 default", {32'b0, rd_data}, 64'h0000_0000_FFFF_BFFF);

        // R5: set bit 14 enables index 14; still in reset so not running (R7)
        bus_wr(12'h080, 32'h0000_4000);
        check_outputs("bit14 set");
        check("R5 clk_en14", {63'b0, clk_en[14]}, 64'd1);
        check("R7 clk_run14 in reset", {63'b0, clk_run[14]}, 64'd0);
        bus_wr(12'h044, 32'h0000_4000);
        check("R7 clk_run14 released", {63'b0, clk_run[14]}, 64'd1);
        // R4: clearing a normal stop bit enables it
        bus_wr(12'h084, 32'h0000_0001);
        check("R4 clk_en0", {63'b0, clk_en[0]}, 64'd1);
        // R1: index 33 is bit 1 of the upper words
        bus_wr(12'h094, 32'h0000_0002);
        bus_wr(12'h054, 32'h0000_0002);
        check("R1 clk_run33", {63'b0, clk_run[33]}, 64'd1);
        check_outputs("index33");
        // R10: undefined and unaligned writes are ignored
        bus_wr(12'h048, 32'hFFFF_FFFF);
        bus_wr(12'h042, 32'hFFFF_FFFF);
        bus_wr(12'h088, 32'hFFFF_FFFF);
        check_outputs("R10 after undefined writes");
        bus_rd(12'h048);
        bus_rd(12'h054);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] a;
            logic [31:0] d;
            a = ($urandom % 4 == 0) ? AW'($urandom) : defs[$urandom % 8];
            d = $urandom;
            if ($urandom % 3 == 0) bus_rd(a);
            else begin
                bus_wr(a, d);
                check_outputs("random R2/R3");
            end
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule